// File: doc/BRIEF.md
# Control Register Bank with Atomic Set, Clear and Toggle Aliases

This block holds a bank of 32-bit control registers behind a simple word-aligned bus. The bus window is 0x8000 bytes and has two groups. The lower half, starting at byte 0x0000, holds plain registers that can only be replaced by a write. The upper half, starting at byte 0x4000, holds aliased registers. Each aliased register takes four consecutive word slots.

The slot at word offset 0 is the register itself, and a write there replaces it. A write to word offset 1 sets bits, a write to word offset 2 clears bits, and a write to word offset 3 inverts bits. In each case only the bits that are 1 in the write data are affected. Software can therefore change single fields atomically, with no read-modify-write sequence. A read of any of the four slots returns the register itself.

Some aliased registers are marked as clock-generator controls by a parameter mask. On reset, bit 31 of each of these registers is forced to 1, which presents them as locked. Reads return data one cycle after the request, together with a valid strobe. Accesses that are malformed or fall outside the window raise a one-cycle error pulse.

Top module: `regbank_sca`

## Requirements
- R1: While rst_ni is low, plain register i holds 32'h5A00_0000 | i, and aliased register j holds 32'h0001_3000 | j. Bit 31 of aliased register j is also 1 when bit j of PLL_MASK is 1 (default PLL_MASK = 6'b011011, NUM_PLAIN = 8, NUM_ALIAS = 6).
- R2: Plain register i sits at byte address 4*i. Aliased register j has its base slot at byte address 0x4000 + 16*j. A write to either address replaces all 32 bits with wdata_i.
- R3: A write to byte address 0x4000 + 16*j + 4 (the set slot) ORs wdata_i into aliased register j.
- R4: A write to byte address 0x4000 + 16*j + 8 (the clear slot) clears in register j every bit that is 1 in wdata_i.
- R5: A write to byte address 0x4000 + 16*j + 12 (the toggle slot) XORs wdata_i into register j.
- R6: A read of any of the four slots of aliased register j returns the current value of register j.
- R7: rdata_o and rvalid_o are valid in the cycle after rd_en_i is sampled, and rvalid_o is low after a cycle with no read. When a read and a write to the same register are sampled in the same cycle, the read returns the value held before the write.
- R8: A word-aligned address below 0x8000 that has no backing register (plain index >= NUM_PLAIN, or aliased index >= NUM_ALIAS) reads as zero and ignores writes, and err_o stays low.
- R9: An access with addr_i >= 0x8000 or addr_i[1:0] != 0 reads as zero and changes no register. For such an access, err_o is high for exactly the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Byte address of the access |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| err_o | output | 1 | One-cycle pulse after a malformed or out-of-window access |

## Verification
The assertions assume that at most one write is presented per cycle and that addr_i and wdata_i are stable during the sampled cycle. They place no limit on combining a read and a write in one cycle, and the bench deliberately issues such combined accesses, including both to the same register. The random stimulus mostly targets backed registers and their alias slots. It mixes in reserved indices, misaligned offsets and addresses above the window. Inputs are always driven on the falling edge, so the address seen at the rising edge is never ambiguous.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned WIDX_W = 12;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } alias_op_e;

  typedef struct packed {
    logic              bad;
    logic              plain_hit;
    logic              alias_hit;
    logic [WIDX_W-1:0] idx;
    alias_op_e         op;
  } dec_t;

  function automatic logic [DATA_W-1:0] plain_rst(int unsigned i);
    return 32'h5A00_0000 | DATA_W'(i);
  endfunction

  function automatic logic [DATA_W-1:0] alias_rst(int unsigned j);
    return 32'h0001_3000 | DATA_W'(j);
  endfunction
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int unsigned NUM_PLAIN = 8,
  parameter int unsigned NUM_ALIAS = 6,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  localparam logic [WIDX_W-1:0]   PLAIN_LIM = WIDX_W'(NUM_PLAIN);
  localparam logic [WIDX_W-3:0]   ALIAS_LIM = (WIDX_W-2)'(NUM_ALIAS);

  logic [WIDX_W-1:0] word;
  assign word = addr_i[13:2];

  always_comb begin
    dec_o     = '0;
    dec_o.bad = (addr_i[1:0] != 2'b00) | (|addr_i[ADDR_W-1:15]);
    if (!dec_o.bad) begin
      if (!addr_i[14]) begin
        dec_o.idx       = word;
        dec_o.op        = OP_WRITE;
        dec_o.plain_hit = (word < PLAIN_LIM);
      end else begin
        dec_o.idx       = {2'b00, word[WIDX_W-1:2]};
        dec_o.op        = alias_op_e'(word[1:0]);
        dec_o.alias_hit = (word[WIDX_W-1:2] < ALIAS_LIM);
      end
    end
  end
endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int unsigned          NUM_PLAIN = 8,
  parameter int unsigned          NUM_ALIAS = 6,
  parameter logic [NUM_ALIAS-1:0] PLL_MASK  = 6'b011011,
  parameter int unsigned          LOCK_BIT  = 31
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  dec_t                             dec_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q_o,
  output logic [NUM_ALIAS-1:0][DATA_W-1:0] alias_q_o
);
  localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;

  for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
    localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(i);
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        r_q <= plain_rst(i);
      else if (we_i && dec_i.plain_hit && dec_i.idx == MY_IDX) r_q <= wdata_i;
    end
    assign plain_q_o[i] = r_q;
  end

  for (genvar j = 0; j < NUM_ALIAS; j++) begin : g_alias
    localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(j);
    localparam logic [DATA_W-1:0] RST_V  =
      alias_rst(j) | (PLL_MASK[j] ? LOCK_MASK : '0);
    logic [DATA_W-1:0] r_q;
    logic [DATA_W-1:0] r_d;
    always_comb begin
      unique case (dec_i.op)
        OP_SET:    r_d = r_q | wdata_i;
        OP_CLEAR:  r_d = r_q & ~wdata_i;
        OP_TOGGLE: r_d = r_q ^ wdata_i;
        default:   r_d = wdata_i;
      endcase
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        r_q <= RST_V;
      else if (we_i && dec_i.alias_hit && dec_i.idx == MY_IDX) r_q <= r_d;
    end
    assign alias_q_o[j] = r_q;
  end
endmodule

// File: rtl/regbank_rdport.sv
module regbank_rdport
  import regbank_pkg::*;
#(
  parameter int unsigned NUM_PLAIN = 8,
  parameter int unsigned NUM_ALIAS = 6
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             rd_en_i,
  input  logic                             wr_en_i,
  input  logic                             bad_i,
  input  logic                             plain_hit_i,
  input  logic                             alias_hit_i,
  input  logic [WIDX_W-1:0]                idx_i,
  input  logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q_i,
  input  logic [NUM_ALIAS-1:0][DATA_W-1:0] alias_q_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic                             rvalid_o,
  output logic                             err_o
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_PLAIN; i++)
      if (plain_hit_i && idx_i == WIDX_W'(i)) sel = plain_q_i[i];
    for (int j = 0; j < NUM_ALIAS; j++)
      if (alias_hit_i && idx_i == WIDX_W'(j)) sel = alias_q_i[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      err_o    <= bad_i & (rd_en_i | wr_en_i);
      if (rd_en_i) rdata_o <= sel;
    end
  end
endmodule

// File: rtl/regbank_sca.sv
module regbank_sca
  import regbank_pkg::*;
#(
  parameter int unsigned          NUM_PLAIN = 8,
  parameter int unsigned          NUM_ALIAS = 6,
  parameter logic [NUM_ALIAS-1:0] PLL_MASK  = 6'b011011,
  parameter int unsigned          LOCK_BIT  = 31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  output logic        err_o
);
  dec_t                             dec;
  logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q;
  logic [NUM_ALIAS-1:0][DATA_W-1:0] alias_q;

  regbank_decode #(
    .NUM_PLAIN(NUM_PLAIN), .NUM_ALIAS(NUM_ALIAS), .ADDR_W(16)
  ) u_decode (
    .addr_i(addr_i), .dec_o(dec)
  );

  regbank_store #(
    .NUM_PLAIN(NUM_PLAIN), .NUM_ALIAS(NUM_ALIAS),
    .PLL_MASK(PLL_MASK), .LOCK_BIT(LOCK_BIT)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en_i), .dec_i(dec),
    .wdata_i(wdata_i), .plain_q_o(plain_q), .alias_q_o(alias_q)
  );

  regbank_rdport #(
    .NUM_PLAIN(NUM_PLAIN), .NUM_ALIAS(NUM_ALIAS)
  ) u_rdport (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .bad_i(dec.bad), .plain_hit_i(dec.plain_hit), .alias_hit_i(dec.alias_hit),
    .idx_i(dec.idx), .plain_q_i(plain_q), .alias_q_i(alias_q),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o)
  );
endmodule

// File: rtl/regbank_sca_chk.sv
module regbank_sca_chk #(
  parameter int unsigned NUM_PLAIN = 8,
  parameter int unsigned NUM_ALIAS = 6
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [15:0]                   addr_i,
  input logic                          wr_en_i,
  input logic                          rd_en_i,
  input logic [31:0]                   wdata_i,
  input logic [31:0]                   rdata_o,
  input logic                          rvalid_o,
  input logic                          err_o,
  input logic [NUM_PLAIN-1:0][31:0]    plain_q,
  input logic [NUM_ALIAS-1:0][31:0]    alias_q
);
  logic       bad;
  logic       in_alias;
  logic [9:0] base;
  logic       alias_ok;
  logic       reserved;
  logic [31:0] pre;
  logic [31:0] cur;

  assign bad      = (addr_i[1:0] != 2'b00) || addr_i[15];
  assign in_alias = !bad && addr_i[14];
  assign base     = addr_i[13:4];
  assign alias_ok = in_alias && (32'(base) < NUM_ALIAS);
  assign reserved = !bad && (addr_i[14] ? (32'(base) >= NUM_ALIAS)
                                        : (32'(addr_i[13:2]) >= NUM_PLAIN));

  logic        chk_q;
  logic [1:0]  op_q;
  logic [9:0]  base_q;
  logic [31:0] pre_q;
  logic [31:0] wd_q;

  always_comb begin
    pre = '0;
    cur = '0;
    for (int j = 0; j < NUM_ALIAS; j++) begin
      if (32'(base) == j)   pre = alias_q[j];
      if (32'(base_q) == j) cur = alias_q[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q  <= 1'b0;
      op_q   <= '0;
      base_q <= '0;
      pre_q  <= '0;
      wd_q   <= '0;
    end else begin
      chk_q  <= wr_en_i && alias_ok;
      op_q   <= addr_i[3:2];
      base_q <= base;
      pre_q  <= pre;
      wd_q   <= wdata_i;
    end
  end

  assert_set_or_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_q && op_q == 2'd1) |-> cur == (pre_q | wd_q));
  assert_clear_andn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_q && op_q == 2'd2) |-> cur == (pre_q & ~wd_q));
  assert_toggle_xor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_q && op_q == 2'd3) |-> cur == (pre_q ^ wd_q));
  assert_rvalid_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  assert_rvalid_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  assert_reserved_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && reserved) |=> (rdata_o == 32'd0 && !err_o));
  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_en_i || wr_en_i) && bad) |=> err_o);
  assert_err_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((rd_en_i || wr_en_i) && bad) |=> !err_o);
  assert_bad_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (bad || reserved)) |=> ($stable(plain_q) && $stable(alias_q)));
endmodule

bind regbank_sca regbank_sca_chk #(
  .NUM_PLAIN(NUM_PLAIN), .NUM_ALIAS(NUM_ALIAS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .rvalid_o(rvalid_o), .err_o(err_o), .plain_q(plain_q), .alias_q(alias_q)
);

// File: tb/regbank_sca_tb.sv
module regbank_sca_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NA = 6;
  localparam logic [NA-1:0] PLLM = 6'b011011;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        err;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_plain [NP];
  logic [31:0] m_alias [NA];

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_sca #(.NUM_PLAIN(NP), .NUM_ALIAS(NA), .PLL_MASK(PLLM), .LOCK_BIT(31)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .err_o(err)
  );

  function automatic logic [31:0] exp_rst_plain(int i);
    return 32'h5A00_0000 | 32'(i);
  endfunction

  function automatic logic [31:0] exp_rst_alias(int j);
    return 32'h0001_3000 | 32'(j) | (PLLM[j] ? 32'h8000_0000 : 32'h0);
  endfunction

  function automatic bit is_bad(logic [15:0] a);
    return (a[1:0] != 2'b00) || (a >= 16'h8000);
  endfunction

  function automatic logic [31:0] mdl_read(logic [15:0] a);
    int w;
    if (is_bad(a)) return '0;
    w = int'(a[13:2]);
    if (a < 16'h4000) return (w < NP) ? m_plain[w] : '0;
    return ((w / 4) < NA) ? m_alias[w / 4] : '0;
  endfunction

  task automatic mdl_write(logic [15:0] a, logic [31:0] d);
    int w;
    int b;
    if (is_bad(a)) return;
    w = int'(a[13:2]);
    if (a < 16'h4000) begin
      if (w < NP) m_plain[w] = d;
    end else begin
      b = w / 4;
      if (b < NA) begin
        case (w % 4)
          0: m_alias[b] = d;
          1: m_alias[b] = m_alias[b] | d;
          2: m_alias[b] = m_alias[b] & ~d;
          default: m_alias[b] = m_alias[b] ^ d;
        endcase
      end
    end
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic access(bit we, bit re, logic [15:0] a, logic [31:0] d, string tag);
    logic [31:0] exp_rd;
    bit exp_err;
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d;
    exp_rd  = mdl_read(a);
    exp_err = is_bad(a) && (we || re);
    @(negedge clk);
    if (we) mdl_write(a, d);
    wr_en = 1'b0; rd_en = 1'b0;
    if (re) check(rdata == exp_rd, tag, rdata, exp_rd);
    check(rvalid == re, {tag, " rvalid R7"}, 32'(rvalid), 32'(re));
    check(err == exp_err, {tag, " err"}, 32'(err), 32'(exp_err));
  endtask

  task automatic rd(logic [15:0] a, string tag);
    access(1'b0, 1'b1, a, '0, tag);
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d, string tag);
    access(1'b1, 1'b0, a, d, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NP; i++) m_plain[i] = exp_rst_plain(i);
    for (int j = 0; j < NA; j++) m_alias[j] = exp_rst_alias(j);
    repeat (3) @(negedge clk);
    check(rvalid == 1'b0 && err == 1'b0, "R1 outputs in reset", {30'b0, rvalid, err}, 32'h0);
    rst_ni = 1'b1;

    // R1: reset contents, including lock bit on marked registers
    for (int i = 0; i < NP; i++) rd(16'(4 * i), "R1 plain reset");
    for (int j = 0; j < NA; j++) rd(16'h4000 + 16'(16 * j), "R1 alias reset");

    // R2: replacing writes
    wr(16'h0008, 32'hDEAD_BEEF, "R2 plain write");
    rd(16'h0008, "R2 plain readback");
    wr(16'h001C, 32'h0000_0001, "R2 last plain");
    rd(16'h001C, "R2 last plain readback");
    wr(16'h4010, 32'h1234_5678, "R2 alias base write");
    rd(16'h4010, "R2 alias base readback");

    // R3..R5: set, clear, toggle on register 1
    wr(16'h4014, 32'hF000_000F, "R3 set");
    rd(16'h4010, "R3 set result");
    wr(16'h4018, 32'h1200_0008, "R4 clear");
    rd(16'h4010, "R4 clear result");
    wr(16'h401C, 32'hFFFF_0000, "R5 toggle");
    rd(16'h4010, "R5 toggle result");
    wr(16'h405C, 32'h8000_0000, "R5 toggle lock bit");
    rd(16'h4050, "R5 lock bit toggled");

    // R6: every alias slot reads the base
    for (int s = 0; s < 4; s++) rd(16'h4020 + 16'(4 * s), "R6 alias slot read");
    for (int s = 1; s < 4; s++) rd(16'h4010 + 16'(4 * s), "R6 alias slot read reg1");

    // R7: read and write together to same register return old value
    access(1'b1, 1'b1, 16'h0004, 32'hCAFE_0001, "R7 same-cycle plain");
    rd(16'h0004, "R7 new value visible");
    access(1'b1, 1'b1, 16'h4034, 32'h0F0F_0F0F, "R7 same-cycle set alias");
    rd(16'h4030, "R7 set visible");

    // R8: reserved indices
    wr(16'(4 * NP), 32'hFFFF_FFFF, "R8 reserved plain write");
    rd(16'(4 * NP), "R8 reserved plain read");
    rd(16'h3FFC, "R8 top of plain half");
    wr(16'h4000 + 16'(16 * NA) + 16'h4, 32'hFFFF_FFFF, "R8 reserved alias set");
    rd(16'h4000 + 16'(16 * NA), "R8 reserved alias read");
    for (int j = 0; j < NA; j++) rd(16'h4000 + 16'(16 * j), "R8 aliases untouched");

    // R9: malformed or out-of-window
    wr(16'h4001, 32'hFFFF_FFFF, "R9 misaligned write");
    rd(16'h4000, "R9 target unchanged");
    rd(16'h0006, "R9 misaligned read");
    wr(16'h8000, 32'hFFFF_FFFF, "R9 above window write");
    rd(16'h8000, "R9 above window read");
    rd(16'hC010, "R9 high alias image read");
    for (int i = 0; i < NP; i++) rd(16'(4 * i), "R9 plain untouched");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int sel;
      logic [15:0] a;
      logic [31:0] d;
      sel = int'($urandom_range(0, 99));
      d = $urandom();
      if (sel < 35)      a = 16'(4 * $urandom_range(0, NP - 1));
      else if (sel < 75) a = 16'h4000 + 16'(4 * $urandom_range(0, 4 * NA - 1));
      else if (sel < 87) a = 16'h4000 + 16'(4 * $urandom_range(4 * NA, 4095));
      else if (sel < 93) a = 16'(4 * $urandom_range(NP, 4095));
      else               a = 16'($urandom());
      access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, d, "R6 R9 random");
    end
    for (int i = 0; i < NP; i++) rd(16'(4 * i), "R2 final plain");
    for (int j = 0; j < NA; j++) rd(16'h400C + 16'(16 * j), "R6 final alias");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule